// File: doc/BRIEF.md
# DRAM Address Multiplexing Access Sequencer

This block turns a host access request into the row/column strobe sequence that a dynamic RAM expects. The host raises a strobe and presents a flat address. On that rising edge the sequencer latches the address and splits it into two halves. It drives both halves one after the other on a single half-width memory address bus. The row half goes out first, then the row strobe, then the column half, then the column strobe.

While the host keeps its strobe high, both memory strobes stay asserted, so the data transfer can take as long as it needs. When the host drops its strobe, the sequencer releases both memory strobes and waits out a precharge interval before it will start another access. A host strobe that rises during precharge is remembered and served as soon as precharge ends. All setup, hold and precharge times are parameters counted in clock cycles.

Top module: `dram_mux_seq`

## Requirements
- R1: While rst_ni is low, row_stb_o, col_stb_o and busy_o are 0 and mem_addr_o is all zeros.
- R2: The address is captured on the clock edge where host_stb_i is first sampled high after being low. Later changes on addr_i do not affect the access in progress.
- R3: The row half (addr_i bits 0 to 9 of the captured address) is on mem_addr_o for exactly T_ROW_SETUP cycles before row_stb_o rises. It stays there for T_ROW_HOLD cycles after row_stb_o rises.
- R4: The column half (captured bits 10 to 19) is on mem_addr_o for T_COL_SETUP cycles before col_stb_o rises, while row_stb_o is held high. col_stb_o is never high while row_stb_o is low.
- R5: Both strobes stay high as long as host_stb_i stays high. Both fall on the first edge where host_stb_i is sampled low.
- R6: After the strobes fall, a precharge of T_PRECHARGE cycles follows. During it both strobes are low and busy_o is high. If no request is pending, busy_o falls at the end of precharge.
- R7: A rising host_stb_i during precharge captures its address and is held pending. The new access begins on the edge that ends precharge, with the row half on the bus and no idle cycle in between. This also holds for a rise in the last precharge cycle.
- R8: busy_o rises on the capture edge and stays high through the whole access and precharge. With busy_o low, neither strobe is high, and no access starts while host_stb_i stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_stb_i | input | 1 | Host access strobe, active high, held for the whole transfer |
| addr_i | input | 20 | Flat host address, bits 0-9 row, bits 10-19 column |
| mem_addr_o | output | 10 | Multiplexed memory address bus, registered |
| row_stb_o | output | 1 | Row address strobe, active high, registered |
| col_stb_o | output | 1 | Column address strobe, active high, registered |
| busy_o | output | 1 | High from capture until precharge expires, registered |

## Verification
A corrupted sequencer state or dwell counter shifts a strobe edge by one or more cycles. It therefore shows up at the ports within one phase length, as a strobe rising with the wrong half on the bus or a precharge that is too short or too long. A lost pending flag shows up at the end of precharge as busy_o falling instead of a new row phase starting. A stale address latch shows up on mem_addr_o during the access that follows the capture.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_SU,
    ST_ROW_HD,
    ST_COL_SU,
    ST_ACTIVE,
    ST_PRECH
  } seq_state_e;
endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned MA_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              col_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MA_W-1:0]   mem_addr_o
);
  logic [ADDR_W-1:0] lat_q, lat_d;
  logic [MA_W-1:0]   ma_q;

  assign lat_d = capture_i ? addr_i : lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      ma_q  <= '0;
    end else begin
      lat_q <= lat_d;
      ma_q  <= col_sel_i ? lat_d[ADDR_W-1:MA_W] : lat_d[MA_W-1:0];
    end
  end

  assign mem_addr_o = ma_q;

  AST_CAPTURE_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !col_sel_i) |=> mem_addr_o == $past(addr_i[MA_W-1:0])); // R2
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm #(
  parameter int unsigned T_ROW_SETUP = 1,
  parameter int unsigned T_ROW_HOLD  = 1,
  parameter int unsigned T_COL_SETUP = 1,
  parameter int unsigned T_PRECHARGE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_stb_i,
  output logic capture_o,
  output logic col_sel_o,
  output logic row_stb_o,
  output logic col_stb_o,
  output logic busy_o
);
  import dram_seq_pkg::*;

  localparam int unsigned T_SUM = T_ROW_SETUP + T_ROW_HOLD + T_COL_SETUP + T_PRECHARGE;
  localparam int unsigned CNT_W = $clog2(T_SUM + 1);
  localparam int unsigned GAP   = T_PRECHARGE + T_ROW_SETUP;
  localparam int unsigned GAP_W = $clog2(GAP + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             stb_q, rise;
  logic             row_q, col_q, busy_q;

  assign rise = host_stb_i & ~stb_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (rise) state_d = ST_ROW_SU;
      end
      ST_ROW_SU:
        if (cnt_q == CNT_W'(T_ROW_SETUP - 1)) begin
          state_d = ST_ROW_HD;
          cnt_d   = '0;
        end
      ST_ROW_HD:
        if (cnt_q == CNT_W'(T_ROW_HOLD - 1)) begin
          state_d = ST_COL_SU;
          cnt_d   = '0;
        end
      ST_COL_SU:
        if (cnt_q == CNT_W'(T_COL_SETUP - 1)) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end
      ST_ACTIVE: begin
        cnt_d = '0;
        if (!host_stb_i) state_d = ST_PRECH;
      end
      ST_PRECH: begin
        if (rise) pend_d = 1'b1;
        if (cnt_q == CNT_W'(T_PRECHARGE - 1)) begin
          cnt_d   = '0;
          pend_d  = 1'b0;
          state_d = (pend_q | rise) ? ST_ROW_SU : ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // capture on a fresh strobe only when no access is on the bus
  assign capture_o = rise & ((state_q == ST_IDLE) | (state_q == ST_PRECH));
  assign col_sel_o = (state_d == ST_COL_SU) | (state_d == ST_ACTIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      stb_q   <= 1'b0;
      row_q   <= 1'b0;
      col_q   <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      stb_q   <= host_stb_i;
      row_q   <= (state_d == ST_ROW_HD) | (state_d == ST_COL_SU) | (state_d == ST_ACTIVE);
      col_q   <= (state_d == ST_ACTIVE);
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  assign row_stb_o = row_q;
  assign col_stb_o = col_q;
  assign busy_o    = busy_q;

  // gap tracker: cycles with row strobe low since it last fell
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_q | row_q;
      if (row_q) gap_q <= '0;
      else if (gap_q != GAP_W'(GAP)) gap_q <= gap_q + 1'b1;
    end
  end

  AST_COL_NEEDS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_stb_o |-> row_stb_o); // R4
  AST_HOLD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_o && host_stb_i) |=> (col_stb_o && row_stb_o)); // R5
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_o && !host_stb_i) |=> (!col_stb_o && !row_stb_o && busy_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!row_stb_o && !col_stb_o)); // R8
  AST_PRECHARGE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(row_stb_o) && seen_q) |-> gap_q >= GAP_W'(GAP)); // R6
endmodule

// File: rtl/dram_mux_seq.sv
module dram_mux_seq #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned T_ROW_SETUP = 1,
  parameter int unsigned T_ROW_HOLD  = 1,
  parameter int unsigned T_COL_SETUP = 1,
  parameter int unsigned T_PRECHARGE = 3,
  localparam int unsigned MA_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic              row_stb_o,
  output logic              col_stb_o,
  output logic              busy_o
);
  logic capture, col_sel;

  dram_seq_fsm #(
    .T_ROW_SETUP(T_ROW_SETUP),
    .T_ROW_HOLD (T_ROW_HOLD),
    .T_COL_SETUP(T_COL_SETUP),
    .T_PRECHARGE(T_PRECHARGE)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .host_stb_i(host_stb_i),
    .capture_o (capture),
    .col_sel_o (col_sel),
    .row_stb_o (row_stb_o),
    .col_stb_o (col_stb_o),
    .busy_o    (busy_o)
  );

  dram_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .col_sel_i (col_sel),
    .addr_i    (addr_i),
    .mem_addr_o(mem_addr_o)
  );

  AST_ROW_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_stb_o) |-> $stable(mem_addr_o)); // R3
  AST_COL_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(col_stb_o) |-> $stable(mem_addr_o)); // R4
endmodule

// File: tb/sim_dram_mux_seq.sv
module sim_dram_mux_seq;
  localparam int RS = 2, RH = 1, CS = 2, PR = 3;
  localparam int TS = RS + RH + CS;

  logic        clk = 1'b0, rst_n = 1'b0, stb = 1'b0;
  logic [19:0] addr = '0;
  logic [9:0]  ma;
  logic        row, col, busy;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  dram_mux_seq #(.T_ROW_SETUP(RS), .T_ROW_HOLD(RH), .T_COL_SETUP(CS), .T_PRECHARGE(PR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_stb_i(stb), .addr_i(addr),
    .mem_addr_o(ma), .row_stb_o(row), .col_stb_o(col), .busy_o(busy));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // stb is high before the coming edge; check the whole access, drop stb after hold cycles
  task automatic seq_check(input logic [19:0] a, input int hold, input string pfx);
    for (int j = 1; j <= TS + hold; j++) begin
      @(negedge clk);
      if (j == 1) addr = ~a; // R2: late address changes ignored
      chk({pfx, " R8 busy"}, busy, 1);
      if (j <= RS) begin
        chk({pfx, " R3 row setup ras"}, row, 0);
        chk({pfx, " R3 row setup ma"}, ma, a[9:0]);
        chk({pfx, " R4 cas low"}, col, 0);
      end else if (j <= RS + RH) begin
        chk({pfx, " R3 row hold ras"}, row, 1);
        chk({pfx, " R3 row hold ma"}, ma, a[9:0]);
        chk({pfx, " R4 cas low"}, col, 0);
      end else if (j <= TS) begin
        chk({pfx, " R4 col setup ras"}, row, 1);
        chk({pfx, " R4 R2 col setup ma"}, ma, a[19:10]);
        chk({pfx, " R4 col setup cas"}, col, 0);
      end else begin
        chk({pfx, " R5 active ras"}, row, 1);
        chk({pfx, " R5 active cas"}, col, 1);
        chk({pfx, " R4 R2 active ma"}, ma, a[19:10]);
      end
    end
    stb = 1'b0;
  endtask

  // pend_at==0: no new request; otherwise raise stb with address b after sample pend_at
  task automatic pre_check(input int pend_at, input logic [19:0] b);
    for (int p = 1; p <= PR; p++) begin
      @(negedge clk);
      chk("R6 precharge ras", row, 0);
      chk("R6 precharge cas", col, 0);
      chk("R6 precharge busy", busy, 1);
      if (p == pend_at) begin
        stb  = 1'b1;
        addr = b;
      end
    end
    if (pend_at == 0) begin
      @(negedge clk);
      chk("R6 precharge end busy", busy, 0);
      chk("R8 idle ras", row, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset ras", row, 0);
    chk("R1 reset cas", col, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ma", ma, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_idle;
    addr = 20'hFFFFF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 no strobe busy", busy, 0);
      chk("R8 no strobe ras", row, 0);
    end
  endtask

  task automatic t_basic;
    stb = 1'b1; addr = 20'hA53C7;
    seq_check(20'hA53C7, 1, "basic");
    pre_check(0, '0);
  endtask

  task automatic t_long;
    stb = 1'b1; addr = 20'h3FF00;
    seq_check(20'h3FF00, 6, "long");
    pre_check(0, '0);
  endtask

  task automatic t_pending_mid;
    stb = 1'b1; addr = 20'h12345;
    seq_check(20'h12345, 2, "first");
    pre_check(1, 20'hCAFE1);
    seq_check(20'hCAFE1, 2, "R7 mid");
    pre_check(0, '0);
  endtask

  task automatic t_pending_last;
    stb = 1'b1; addr = 20'h0F0F0;
    seq_check(20'h0F0F0, 1, "first");
    pre_check(PR, 20'h80001);
    seq_check(20'h80001, 3, "R7 last");
    pre_check(0, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_idle;
    t_basic;
    t_long;
    t_pending_mid;
    t_pending_last;
    t_idle;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule